// File: doc/BRIEF.md
# Nibble-Serial Accumulator Processor Core

This block is a small 4-bit processor that sits in a package with eight input pins and eight output pins. Its inputs are a clock, a synchronous active-low reset, one 4-bit nibble input and two external condition flags. Opcodes and operands both arrive on the nibble input, one nibble per instruction step. Its only output is one 8-bit bus that is shared in time. Each instruction is a series of phase pairs. In the first phase of a pair the bus carries a full 8-bit address. In the second phase the upper nibble carries strobes that say what kind of cycle just ran, and the lower nibble carries the accumulator (or the top of the branch register during a jump).

The program memory, the address latch and any other glue logic sit outside the block. External logic latches each address phase and returns the addressed nibble during the status phase that follows. The core samples that nibble on the clock edge that ends the status phase.

The state inside the core is a 4-bit accumulator, a carry flag, an 8-bit program/data address register and a 12-bit branch register. The branch register is built up one nibble at a time and is used as the target for jumps and stores.

Top module: `cpu4_core`

## Requirements
- R1: While `rst_ni` is low at a rising edge, the core returns to a fetch-address phase with address 0x00. Reset also clears the accumulator, the carry flag and the 12-bit branch register, so the first status phase after reset shows 0x90.
- R2: Every instruction starts with an address phase and then a status phase. The address phase drives the fetch address. The status phase drives `{1,0,0,1, acc}`, where bit 7 is the fetch strobe, bit 6 the jump strobe, bit 5 the write strobe and bit 4 the address-marker strobe. The opcode is sampled at the end of that status phase, and the address then advances by one.
- R3: Opcodes 0 to 5 and 10 take an operand. The core then runs a second pair: the operand address (the next address) and then a status phase `{0,0,0,1, acc}`. The operand is sampled at the end of that status phase, and the address advances by one again.
- R4: Opcode 0 loads the operand into the accumulator. Opcodes 3, 4 and 5 AND, OR and XOR the operand into the accumulator. None of these four changes the carry.
- R5: Opcode 1 adds the operand and the carry, and the carry-out goes to the carry flag. Opcode 2 subtracts the operand and the carry, and the borrow goes to the carry flag. Both wrap modulo 16.
- R6: Opcode 6 inverts the accumulator. Opcode 7 rotates the 5-bit value {carry, acc} left: the old accumulator bit 3 becomes the carry, and the old carry enters at bit 0.
- R7: Opcode 8 sets the carry flag and opcode 9 clears it. Neither changes the accumulator.
- R8: Opcode 10 shifts the operand nibble into the low end of the 12-bit branch register and drops the top nibble. Opcode 11 does the same with the accumulator.
- R9: Opcode 12 runs a branch pair: the address phase drives branch[7:0], and the status phase drives `{0,1,0,0, branch[11:8]}`. The next fetch then comes from branch[7:0].
- R10: Opcodes 13 and 14 jump as in R9 only when condition flag 0 or flag 1, sampled with the opcode, is 1. Otherwise no branch pair runs, and the next fetch comes from the address that follows the opcode.
- R11: Opcode 15 runs a branch pair: the address phase drives branch[7:0], and the status phase drives `{0,0,1,0, acc}` as a write of the accumulator to that address. The accumulator, the carry and the branch register do not change.
- R12: Address arithmetic is 8-bit, so stepping past 0xFF continues at 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every phase is one cycle |
| rst_ni | input | 1 | Synchronous active-low reset |
| nib_i | input | 4 | Opcode or operand nibble returned by external memory |
| cond_i | input | 2 | External condition flags for the conditional jumps |
| bus_o | output | 8 | Time-shared address / strobe-and-data bus |

## Verification
The bench builds the core with its default parameters: a 4-bit nibble, an 8-bit address, a 12-bit branch register and a reset address of 0x00. With these values the whole 256-entry address space is small enough to model as a bench array, so a random program can roam all of it, write over its own code and step past 0xFF. Three branch-register shifts bring every bit of the 12-bit register to the bus. The random condition flags drive both outcomes of each conditional jump. A directed program comes first, and it places carry and borrow at their wrap points.

// File: rtl/cpu4_pkg.sv
// Shared widths, opcode and phase encodings for the nibble-serial core.
// Assumes a 4-bit opcode space; the widths below are fixed by that.
package cpu4_pkg;

    localparam int NIB_W  = 4;
    localparam int ADDR_W = 2 * NIB_W;
    localparam int DR_W   = 3 * NIB_W;
    localparam int BUS_W  = 2 * NIB_W;

    // Strobe positions inside the upper nibble of a status phase
    localparam int STB_FETCH = 3;
    localparam int STB_JUMP  = 2;
    localparam int STB_WRITE = 1;
    localparam int STB_ADDR  = 0;

    typedef enum logic [NIB_W-1:0] {
        OP_LDI  = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_CPL  = 4'd6,
        OP_ROL  = 4'd7,
        OP_SETC = 4'd8,
        OP_CLRC = 4'd9,
        OP_DSH  = 4'd10,
        OP_DSA  = 4'd11,
        OP_JMP  = 4'd12,
        OP_JC0  = 4'd13,
        OP_JC1  = 4'd14,
        OP_STA  = 4'd15
    } opcode_e;

    typedef enum logic [2:0] {
        PH_IADR = 3'd0,
        PH_ISTS = 3'd1,
        PH_OADR = 3'd2,
        PH_OSTS = 3'd3,
        PH_DADR = 3'd4,
        PH_DSTS = 3'd5
    } phase_e;

    // True for opcodes that fetch a second nibble as an operand
    function automatic logic takes_operand(input logic [NIB_W-1:0] op);
        return (op <= OP_XOR) || (op == OP_DSH);
    endfunction

endpackage

// File: rtl/cpu4_alu.sv
// Combinational 4-bit ALU of the accumulator core.
// Decides the new accumulator, the new carry and the write enables for one
// executed opcode. Assumes the operand is meaningful only for operand opcodes.
module cpu4_alu
    import cpu4_pkg::*;
(
    input  opcode_e          op_i,
    input  logic [NIB_W-1:0] acc_i,
    input  logic [NIB_W-1:0] opnd_i,
    input  logic             carry_i,
    output logic [NIB_W-1:0] res_o,
    output logic             carry_o,
    output logic             acc_we_o,
    output logic             carry_we_o
);

    logic [NIB_W:0] sum_w;
    logic [NIB_W:0] diff_w;

    // Wide add and subtract, carry or borrow in the top bit
    always_comb begin
        sum_w  = {1'b0, acc_i} + {1'b0, opnd_i} + {{NIB_W{1'b0}}, carry_i};
        diff_w = {1'b0, acc_i} - {1'b0, opnd_i} - {{NIB_W{1'b0}}, carry_i};
    end

    // Result and enable selection per opcode
    always_comb begin
        res_o      = acc_i;
        carry_o    = carry_i;
        acc_we_o   = 1'b0;
        carry_we_o = 1'b0;
        unique case (op_i)
            OP_LDI: begin res_o = opnd_i;          acc_we_o = 1'b1; end
            OP_AND: begin res_o = acc_i & opnd_i;  acc_we_o = 1'b1; end
            OP_OR:  begin res_o = acc_i | opnd_i;  acc_we_o = 1'b1; end
            OP_XOR: begin res_o = acc_i ^ opnd_i;  acc_we_o = 1'b1; end
            OP_CPL: begin res_o = ~acc_i;          acc_we_o = 1'b1; end
            OP_ADD: begin
                res_o      = sum_w[NIB_W-1:0];
                carry_o    = sum_w[NIB_W];
                acc_we_o   = 1'b1;
                carry_we_o = 1'b1;
            end
            OP_SUB: begin
                res_o      = diff_w[NIB_W-1:0];
                carry_o    = diff_w[NIB_W];
                acc_we_o   = 1'b1;
                carry_we_o = 1'b1;
            end
            OP_ROL: begin
                res_o      = {acc_i[NIB_W-2:0], carry_i};
                carry_o    = acc_i[NIB_W-1];
                acc_we_o   = 1'b1;
                carry_we_o = 1'b1;
            end
            OP_SETC: begin carry_o = 1'b1; carry_we_o = 1'b1; end
            OP_CLRC: begin carry_o = 1'b0; carry_we_o = 1'b1; end
            default: ;
        endcase
    end

endmodule

// File: rtl/cpu4_seq.sv
// Phase sequencer: steps the address/status pairs of each instruction,
// holds the opcode and tells the register file when to execute, advance or
// load the address. Assumes the opcode and flags are valid at the end of
// the fetch status phase, and the operand at the end of the operand status.
module cpu4_seq
    import cpu4_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NIB_W-1:0] nib_i,
    input  logic [1:0]       cond_i,
    output phase_e           phase_o,
    output opcode_e          ir_o,
    output opcode_e          exec_op_o,
    output logic             exec_en_o,
    output logic             mar_inc_o,
    output logic             mar_load_o
);

    phase_e  phase_q, phase_d;
    opcode_e ir_q;
    opcode_e nib_op;
    logic    branch_pair;

    assign nib_op = opcode_e'(nib_i);

    // Decide at fetch time whether a branch-register pair follows
    always_comb begin
        branch_pair = (nib_op == OP_JMP) || (nib_op == OP_STA)
                   || ((nib_op == OP_JC0) && cond_i[0])
                   || ((nib_op == OP_JC1) && cond_i[1]);
    end

    // Next-phase selection
    always_comb begin
        phase_d = PH_IADR;
        unique case (phase_q)
            PH_IADR: phase_d = PH_ISTS;
            PH_ISTS: begin
                if (takes_operand(nib_i))  phase_d = PH_OADR;
                else if (branch_pair)      phase_d = PH_DADR;
                else                       phase_d = PH_IADR;
            end
            PH_OADR: phase_d = PH_OSTS;
            PH_OSTS: phase_d = PH_IADR;
            PH_DADR: phase_d = PH_DSTS;
            PH_DSTS: phase_d = PH_IADR;
            default: phase_d = PH_IADR;
        endcase
    end

    // Phase register and opcode capture
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phase_q <= PH_IADR;
            ir_q    <= OP_LDI;
        end else begin
            phase_q <= phase_d;
            if (phase_q == PH_ISTS) ir_q <= nib_op;
        end
    end

    // Execute, advance and load strobes toward the register file
    always_comb begin
        exec_op_o  = (phase_q == PH_ISTS) ? nib_op : ir_q;
        exec_en_o  = ((phase_q == PH_ISTS) && !takes_operand(nib_i))
                  || (phase_q == PH_OSTS);
        mar_inc_o  = (phase_q == PH_ISTS) || (phase_q == PH_OSTS);
        mar_load_o = (phase_q == PH_DSTS) && (ir_q != OP_STA);
    end

    assign phase_o = phase_q;
    assign ir_o    = ir_q;

    // R2
    fetch_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_q == PH_IADR) |=> (phase_q == PH_ISTS));

    // R9
    branch_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_q == PH_DADR) |=> (phase_q == PH_DSTS));

    // R10
    cond_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((phase_q == PH_ISTS) && (nib_i == OP_JC0) && !cond_i[0])
        |=> (phase_q == PH_IADR));

    // R3
    operand_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((phase_q == PH_ISTS) && takes_operand(nib_i)) |=> (phase_q == PH_OADR));

endmodule

// File: rtl/cpu4_regs.sv
// Architectural state: accumulator, carry, address register and the 12-bit
// branch register, updated by the sequencer strobes and the ALU.
// Assumes at most one of advance/load is raised in a cycle.
module cpu4_regs
    import cpu4_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  phase_e            phase_i,
    input  opcode_e           exec_op_i,
    input  logic              exec_en_i,
    input  logic              mar_inc_i,
    input  logic              mar_load_i,
    input  logic [NIB_W-1:0]  nib_i,
    output logic [NIB_W-1:0]  acc_o,
    output logic [ADDR_W-1:0] mar_o,
    output logic [DR_W-1:0]   dr_o
);

    localparam int DR_KEEP = DR_W - NIB_W;

    logic [NIB_W-1:0]  acc_q;
    logic              carry_q;
    logic [ADDR_W-1:0] mar_q;
    logic [DR_W-1:0]   dr_q;

    logic [NIB_W-1:0]  alu_res;
    logic              alu_carry;
    logic              alu_acc_we;
    logic              alu_carry_we;

    cpu4_alu u_alu (
        .op_i       (exec_op_i),
        .acc_i      (acc_q),
        .opnd_i     (nib_i),
        .carry_i    (carry_q),
        .res_o      (alu_res),
        .carry_o    (alu_carry),
        .acc_we_o   (alu_acc_we),
        .carry_we_o (alu_carry_we)
    );

    // Accumulator and carry update on execute
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else if (exec_en_i) begin
            if (alu_acc_we)   acc_q   <= alu_res;
            if (alu_carry_we) carry_q <= alu_carry;
        end
    end

    // Branch register: shift a nibble in at the low end
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            dr_q <= '0;
        end else if (exec_en_i && (exec_op_i == OP_DSH)) begin
            dr_q <= {dr_q[DR_KEEP-1:0], nib_i};
        end else if (exec_en_i && (exec_op_i == OP_DSA)) begin
            dr_q <= {dr_q[DR_KEEP-1:0], acc_q};
        end
    end

    // Address register: advance after each sampled nibble or take the target
    always_ff @(posedge clk_i) begin
        if (!rst_ni)         mar_q <= RESET_PC;
        else if (mar_load_i) mar_q <= dr_q[ADDR_W-1:0];
        else if (mar_inc_i)  mar_q <= mar_q + 1'b1;
    end

    assign acc_o = acc_q;
    assign mar_o = mar_q;
    assign dr_o  = dr_q;

    // R3
    mar_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_i == PH_OSTS) |=> (mar_q == ADDR_W'($past(mar_q) + 1'b1)));

    // R9
    jump_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mar_load_i |=> (mar_q == $past(dr_q[ADDR_W-1:0])));

    // R7
    carry_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exec_en_i && (exec_op_i == OP_SETC)) |=> (carry_q && $stable(acc_q)));

    // R11
    store_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_i == PH_DSTS) |=> ($stable(acc_q) && $stable(dr_q) && $stable(carry_q)));

endmodule

// File: rtl/cpu4_core.sv
// Top of the nibble-serial accumulator core. Joins the sequencer and the
// register file and drives the shared 8-bit bus: an address in each address
// phase, strobes plus a data nibble in each status phase.
// Assumes external logic latches address phases and answers in status phases.
module cpu4_core
    import cpu4_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NIB_W-1:0] nib_i,
    input  logic [1:0]       cond_i,
    output logic [BUS_W-1:0] bus_o
);

    phase_e            phase;
    opcode_e           ir;
    opcode_e           exec_op;
    logic              exec_en;
    logic              mar_inc;
    logic              mar_load;
    logic [NIB_W-1:0]  acc;
    logic [ADDR_W-1:0] mar;
    logic [DR_W-1:0]   dr;
    logic [NIB_W-1:0]  stb;
    logic [NIB_W-1:0]  low_nib;

    cpu4_seq u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .nib_i      (nib_i),
        .cond_i     (cond_i),
        .phase_o    (phase),
        .ir_o       (ir),
        .exec_op_o  (exec_op),
        .exec_en_o  (exec_en),
        .mar_inc_o  (mar_inc),
        .mar_load_o (mar_load)
    );

    cpu4_regs #(
        .RESET_PC (RESET_PC)
    ) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .phase_i    (phase),
        .exec_op_i  (exec_op),
        .exec_en_i  (exec_en),
        .mar_inc_i  (mar_inc),
        .mar_load_i (mar_load),
        .nib_i      (nib_i),
        .acc_o      (acc),
        .mar_o      (mar),
        .dr_o       (dr)
    );

    // Strobe nibble and data nibble for the status phases
    always_comb begin
        stb     = '0;
        low_nib = acc;
        unique case (phase)
            PH_ISTS: begin
                stb[STB_FETCH] = 1'b1;
                stb[STB_ADDR]  = 1'b1;
            end
            PH_OSTS: stb[STB_ADDR] = 1'b1;
            PH_DSTS: begin
                if (ir == OP_STA) begin
                    stb[STB_WRITE] = 1'b1;
                end else begin
                    stb[STB_JUMP] = 1'b1;
                    low_nib       = dr[DR_W-1:DR_W-NIB_W];
                end
            end
            default: ;
        endcase
    end

    // Output bus multiplexer across phases
    always_comb begin
        unique case (phase)
            PH_IADR, PH_OADR: bus_o = mar;
            PH_DADR:          bus_o = dr[ADDR_W-1:0];
            default:          bus_o = {stb, low_nib};
        endcase
    end

    // R2
    strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((phase == PH_ISTS) || (phase == PH_OSTS) || (phase == PH_DSTS))
        |-> $onehot0(bus_o[BUS_W-1:BUS_W-3]));

endmodule

// File: tb/tb_cpu4_core.sv
// Bench: phase-accurate memory and instruction-level model of the core.
module tb_cpu4_core;

    localparam int CLK_PERIOD = 10;

    logic       clk_i  = 1'b0;
    logic       rst_ni = 1'b0;
    logic [3:0] nib_i  = 4'h0;
    logic [1:0] cond_i = 2'b00;
    logic [7:0] bus_o;

    cpu4_core dut (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .nib_i  (nib_i),
        .cond_i (cond_i),
        .bus_o  (bus_o)
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    logic [3:0]  mem [256];
    logic [7:0]  m_pc;
    logic [3:0]  m_acc;
    logic        m_c;
    logic [11:0] m_dr;
    int          n_chk  = 0;
    int          n_fail = 0;
    string       ia_tag = "R1";
    string       is_tag = "R1";

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: bus actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic has_opnd(input logic [3:0] op);
        return (op <= 4'd5) || (op == 4'd10);
    endfunction

    // Instruction-level model of R4..R8
    task automatic model_exec(input logic [3:0] op, input logic [3:0] opnd);
        logic [4:0] t;
        is_tag = "R2";
        case (op)
            4'd0: begin m_acc = opnd; is_tag = "R4"; end
            4'd1: begin t = {1'b0, m_acc} + {1'b0, opnd} + {4'd0, m_c};
                        m_acc = t[3:0]; m_c = t[4]; is_tag = "R5"; end
            4'd2: begin t = {1'b0, m_acc} - {1'b0, opnd} - {4'd0, m_c};
                        m_acc = t[3:0]; m_c = t[4]; is_tag = "R5"; end
            4'd3: begin m_acc = m_acc & opnd; is_tag = "R4"; end
            4'd4: begin m_acc = m_acc | opnd; is_tag = "R4"; end
            4'd5: begin m_acc = m_acc ^ opnd; is_tag = "R4"; end
            4'd6: begin m_acc = ~m_acc; is_tag = "R6"; end
            4'd7: begin t = {m_acc, m_c}; m_c = t[4]; m_acc = t[3:0]; is_tag = "R6"; end
            4'd8: begin m_c = 1'b1; is_tag = "R7"; end
            4'd9: begin m_c = 1'b0; is_tag = "R7"; end
            4'd10: begin m_dr = {m_dr[7:0], opnd}; is_tag = "R8"; end
            4'd11: begin m_dr = {m_dr[7:0], m_acc}; is_tag = "R8"; end
            default: ;
        endcase
    endtask

    task automatic model_reset();
        m_pc = 8'h00; m_acc = 4'h0; m_c = 1'b0; m_dr = 12'h000;
        ia_tag = "R1"; is_tag = "R1";
    endtask

    task automatic adv_pc();
        if (m_pc == 8'hFF) ia_tag = "R12";
        m_pc = m_pc + 8'd1;
    endtask

    // One instruction; entered and left at a negedge in a fetch-address phase
    task automatic step_instr();
        logic [3:0] op;
        logic       take;
        cond_i = 2'($urandom);
        chk(bus_o, m_pc, ia_tag);
        ia_tag = "R2";
        nib_i = mem[m_pc];
        @(negedge clk_i);
        chk(bus_o, {4'b1001, m_acc}, is_tag);
        op = mem[m_pc];
        adv_pc();
        if (has_opnd(op)) begin
            @(negedge clk_i);
            chk(bus_o, m_pc, "R3");
            nib_i = mem[m_pc];
            @(negedge clk_i);
            chk(bus_o, {4'b0001, m_acc}, "R3");
            model_exec(op, mem[m_pc]);
            adv_pc();
        end else begin
            model_exec(op, 4'h0);
            take = (op == 4'd12) || (op == 4'd15)
                || ((op == 4'd13) && cond_i[0]) || ((op == 4'd14) && cond_i[1]);
            if (op == 4'd13 || op == 4'd14) ia_tag = "R10";
            if (take) begin
                @(negedge clk_i);
                chk(bus_o, m_dr[7:0], "R8");
                @(negedge clk_i);
                if (op == 4'd15) begin
                    chk(bus_o, {4'b0010, m_acc}, "R11");
                    mem[m_dr[7:0]] = m_acc;
                    is_tag = "R11";
                end else begin
                    chk(bus_o, {4'b0100, m_dr[11:8]}, (op == 4'd12) ? "R9" : "R10");
                    m_pc = m_dr[7:0];
                    if (op == 4'd12) ia_tag = "R9";
                end
            end
        end
        @(negedge clk_i);
    endtask

    // Reset in the middle of an instruction (status phase), then release
    task automatic reset_mid();
        nib_i = mem[m_pc];
        @(negedge clk_i);
        rst_ni = 1'b0;
        @(negedge clk_i);
        chk(bus_o, 8'h00, "R1");
        @(negedge clk_i);
        chk(bus_o, 8'h00, "R1");
        rst_ni = 1'b1;
        model_reset();
    endtask

    // Directed program: carry and borrow wrap, rotate, logic, branch assembly,
    // store, conditional and plain jump, address wrap past 0xFF
    task automatic load_directed();
        logic [3:0] prog [30];
        prog = '{4'h0,4'hF, 4'h8, 4'h1,4'h0, 4'h1,4'h0, 4'h2,4'h2, 4'h2,4'h0,
                 4'h7, 4'h7, 4'h9, 4'h6, 4'h3,4'h5, 4'h4,4'h3, 4'h5,4'hF,
                 4'hA,4'h0, 4'hA,4'hF, 4'hB, 4'hF, 4'hD, 4'hE, 4'hC};
        for (int i = 0; i < 256; i++) mem[i] = 4'h6;
        for (int i = 0; i < 30; i++) mem[i] = prog[i];
        mem[8'hF9] = 4'h0;
        mem[8'hFA] = 4'h5;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        load_directed();
        model_reset();
        repeat (3) @(negedge clk_i);
        chk(bus_o, 8'h00, "R1");
        rst_ni = 1'b1;
        for (int i = 0; i < 80; i++) step_instr();

        reset_mid();
        for (int i = 0; i < 256; i++) mem[i] = 4'($urandom);
        for (int i = 0; i < 1500; i++) step_instr();

        reset_mid();
        for (int i = 0; i < 256; i++) mem[i] = 4'($urandom);
        for (int i = 0; i < 1500; i++) step_instr();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual still running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule